// File: doc/BRIEF.md
# Byte-Register Target for a Two-Wire Serial Bus

This block is the target side of a two-wire serial bus (I2C) in front of a small file of byte-wide registers. It watches already-synchronised samples of the clock and data lines and finds bus conditions. It compares the first byte of each frame against a 7-bit device address given on an input port. It acknowledges the bytes meant for it by pulling the data line low. It also moves register contents in and out, most significant bit first.

A single internal pointer serves both directions. In a write frame, the first data byte after the address loads the pointer. Every later byte is stored at the pointer, and the pointer then steps by one. In a read frame, bytes are sent from the pointer, which steps after each byte, for as long as the controller acknowledges. A write frame followed by a repeated START into a read frame therefore gives a random-access read. Bursts have no length limit. The pointer is a plain binary counter that wraps. Only the first `REG_COUNT` locations exist. The block decides byte by byte whether the current pointer hits one of them: writes that miss are dropped and reads that miss return zero.

The register file sits outside the block. It sees a one-cycle write strobe with address and data, and a combinational read address whose data must come back in the same cycle.

Top module: `i2c_tgt_port`

## Requirements
- R1: A START (data falling while the clock is high) restarts address reception from any phase, including in the middle of a byte. A STOP (data rising while the clock is high) returns the block to idle. Both release the data line within one clock, and neither changes the pointer.
- R2: The first byte after a START is a 7-bit address, most significant bit first, followed by a direction bit (0 = write, 1 = read). When the address equals `dev_addr`, the block holds the data line low for the whole ninth clock.
- R3: When the address does not match, the block does not drive the data line at any point before the next START, and the pointer keeps its value.
- R4: In a write frame, the first data byte is acknowledged and loads the pointer. It causes no register write.
- R5: Each later write byte is acknowledged. It is issued as a one-cycle `wr_en` pulse carrying `wr_addr` equal to the pointer and the received byte. The pointer then increments modulo 2^`PTR_W`. The number of bytes in a burst is unlimited.
- R6: A write byte is dropped (no `wr_en` pulse) when the pointer is at or above `REG_COUNT`. It is still acknowledged and the pointer still increments. This decision is made separately for every byte.
- R7: In a read frame, the block sends the byte at the pointer, most significant bit first, pulling the line low for each 0 bit, and then increments the pointer. It sends another byte after a controller ACK (line low on the ninth clock). After a NACK it releases the line and stays idle.
- R8: A read from a pointer at or above `REG_COUNT` returns 00h, whatever `rd_data` holds.
- R9: A repeated START inside a write frame is accepted, and the pointer it set is used by the read frame that follows.
- R10: The block samples the data line on rising clock edges. It changes `sda_pull` only in the cycle after a falling clock edge (or on a START or STOP), never while the clock stays high. `wr_en` rises only in the cycle after a rising clock edge.
- R11: After reset the data line is released, `wr_en` is low and the pointer (`rd_addr`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock sample |
| sda_i | input | 1 | Synchronised bus data sample |
| dev_addr | input | 7 | Device address this target answers to |
| sda_pull | output | 1 | 1 = pull the data line low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | PTR_W | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | PTR_W | Current pointer, used as the register read address |
| rd_data | input | 8 | Register contents at `rd_addr`, same cycle |

## Verification
The edge detector holds one cycle of line history, so a change on `scl_i` is seen at the first rising `clk` edge after it. As a result, `sda_pull` takes its new value one clock after the input clock falls, and a write pulse together with the pointer step appears one clock after the eighth rising bus-clock edge of a byte. The bench holds every bus phase for two clocks and updates its expected drive in the same half-period in which it lowers the bus clock. It then compares `sda_pull` with that expectation 2 ns after every clock edge, and it checks each write pulse against a queue of expected writes when the pulse occurs. Pointer values and the contents of the register file are compared only once the bus has been idle for two clocks, which is after every update has landed.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
    localparam int BYTE_W  = 8;
    localparam int DEVA_W  = 7;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_ACK_WAIT, PH_ACK, PH_TX, PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR, BK_PTR, BK_DATA
    } kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_s;
endpackage

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    line_s hist_d, hist_q;

    always_comb begin
        hist_d.scl = scl_i;
        hist_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '{scl: 1'b1, sda: 1'b1};
        else        hist_q <= hist_d;
    end

    assign scl_rise = scl_i & ~hist_q.scl;
    assign scl_fall = ~scl_i & hist_q.scl;
    assign start_ev = scl_i & hist_q.scl & hist_q.sda & ~sda_i;
    assign stop_ev  = scl_i & hist_q.scl & ~hist_q.sda & sda_i;
endmodule

// File: rtl/i2c_tgt_regwin.sv
`timescale 1ns/1ps
module i2c_tgt_regwin
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W     = 8,
    parameter int REG_COUNT = 6
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] raw,
    output logic              hit,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int SPAN = 1 << PTR_W;

    generate
        if (REG_COUNT >= SPAN) begin : g_full
            assign hit = 1'b1;
        end else begin : g_part
            assign hit = (int'(ptr) < REG_COUNT);
        end
    endgenerate

    assign rd_byte = hit ? raw : '0;
endmodule

// File: rtl/i2c_tgt_port.sv
`timescale 1ns/1ps
module i2c_tgt_port
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W     = 8,
    parameter int REG_COUNT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DEVA_W-1:0] dev_addr,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_e              phase;
        kind_e               kind;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [PTR_W-1:0]    ptr;
        logic                pull;
        logic                rd_mode;
        logic                mack_ok;
        logic                wr_en;
        logic [PTR_W-1:0]    wr_addr;
        logic [BYTE_W-1:0]   wr_data;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic hit;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] full;

    i2c_tgt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_regwin #(.PTR_W(PTR_W), .REG_COUNT(REG_COUNT)) u_win (
        .ptr     (ctl_q.ptr),
        .raw     (rd_data),
        .hit     (hit),
        .rd_byte (rd_byte)
    );

    assign full = {ctl_q.shreg[BYTE_W-2:0], sda_i};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.wr_en = 1'b0;
        if (start_ev) begin
            ctl_d.phase   = PH_RX;
            ctl_d.kind    = BK_ADDR;
            ctl_d.cnt     = '0;
            ctl_d.pull    = 1'b0;
            ctl_d.rd_mode = 1'b0;
        end else if (stop_ev) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.pull  = 1'b0;
        end else begin
            unique case (ctl_q.phase)
                PH_IDLE: ;
                PH_RX: if (scl_rise) begin
                    ctl_d.shreg = full;
                    ctl_d.cnt   = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.cnt == LAST_BIT) begin
                        ctl_d.phase = PH_ACK_WAIT;
                        unique case (ctl_q.kind)
                            BK_ADDR: begin
                                if (full[BYTE_W-1:1] == dev_addr) ctl_d.rd_mode = full[0];
                                else                              ctl_d.phase   = PH_IDLE;
                            end
                            BK_PTR: ctl_d.ptr = PTR_W'(full);
                            default: begin
                                if (hit) begin
                                    ctl_d.wr_en   = 1'b1;
                                    ctl_d.wr_addr = ctl_q.ptr;
                                    ctl_d.wr_data = full;
                                end
                                ctl_d.ptr = ctl_q.ptr + PTR_W'(1);
                            end
                        endcase
                    end
                end
                PH_ACK_WAIT: if (scl_fall) begin
                    ctl_d.pull  = 1'b1;
                    ctl_d.phase = PH_ACK;
                end
                PH_ACK: if (scl_fall) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.kind == BK_ADDR && ctl_q.rd_mode) begin
                        ctl_d.shreg = rd_byte;
                        ctl_d.ptr   = ctl_q.ptr + PTR_W'(1);
                        ctl_d.pull  = ~rd_byte[BYTE_W-1];
                        ctl_d.phase = PH_TX;
                    end else begin
                        ctl_d.pull  = 1'b0;
                        ctl_d.phase = PH_RX;
                        ctl_d.kind  = (ctl_q.kind == BK_ADDR) ? BK_PTR : BK_DATA;
                    end
                end
                PH_TX: begin
                    if (scl_rise) ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (scl_fall) begin
                        if (ctl_q.cnt == ALL_BITS) begin
                            ctl_d.pull  = 1'b0;
                            ctl_d.phase = PH_MACK;
                        end else begin
                            ctl_d.shreg = {ctl_q.shreg[BYTE_W-2:0], 1'b0};
                            ctl_d.pull  = ~ctl_q.shreg[BYTE_W-2];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) ctl_d.mack_ok = ~sda_i;
                    if (scl_fall) begin
                        if (ctl_q.mack_ok) begin
                            ctl_d.cnt   = '0;
                            ctl_d.shreg = rd_byte;
                            ctl_d.ptr   = ctl_q.ptr + PTR_W'(1);
                            ctl_d.pull  = ~rd_byte[BYTE_W-1];
                            ctl_d.phase = PH_TX;
                        end else begin
                            ctl_d.phase = PH_IDLE;
                        end
                    end
                end
                default: ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_pull = ctl_q.pull;
    assign wr_en    = ctl_q.wr_en;
    assign wr_addr  = ctl_q.wr_addr;
    assign wr_data  = ctl_q.wr_data;
    assign rd_addr  = ctl_q.ptr;
endmodule

// File: rtl/i2c_tgt_port_chk.sv
`timescale 1ns/1ps
module i2c_tgt_port_chk #(
    parameter int PTR_W     = 8,
    parameter int REG_COUNT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             sda_pull,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_addr
);
    AST_PULL_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull)); // R10

    AST_WRITE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(scl_i) && !$past(scl_i, 2))); // R10

    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < REG_COUNT)); // R6

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull); // R1

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !sda_pull); // R1
endmodule

bind i2c_tgt_port i2c_tgt_port_chk #(.PTR_W(PTR_W), .REG_COUNT(REG_COUNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
);

// File: tb/tb_i2c_tgt_port.sv
`timescale 1ns/1ps
module tb_i2c_tgt_port;
    localparam int PTR_W     = 8;
    localparam int REG_COUNT = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             scl;
    logic             sda_m;
    logic [6:0]       dev;
    logic             sda_pull;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [PTR_W-1:0] rd_addr;
    logic [7:0]       rd_data;
    logic             sda_line;

    logic [7:0] rf    [REG_COUNT];
    logic [7:0] model [REG_COUNT];
    int         model_ptr;
    logic [7:0] q_addr [$];
    logic [7:0] q_data [$];
    logic       exp_pull;
    logic       mon_en;
    int         n_chk;
    int         n_fail;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = (int'(rd_addr) < REG_COUNT) ? rf[rd_addr] : 8'hAA;

    i2c_tgt_port #(.PTR_W(PTR_W), .REG_COUNT(REG_COUNT)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .dev_addr (dev),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    always @(posedge clk) begin
        if (wr_en && int'(wr_addr) < REG_COUNT) rf[wr_addr] <= wr_data;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural expectation
    always begin
        @(posedge clk);
        #2;
        if (mon_en) begin
            chk(sda_pull == exp_pull, "R10 data-line drive", sda_pull, exp_pull);
            if (wr_en) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", wr_addr, 0);
                end else begin
                    logic [7:0] ea, ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    chk(wr_addr == ea, "R5 write address", wr_addr, ea);
                    chk(wr_data == ed, "R5 write data", wr_data, ed);
                end
            end
        end
    end

    task automatic slot(input logic bit_v, input logic pull_v, output logic seen);
        @(negedge clk);
        scl = 1'b0;
        exp_pull = pull_v;
        repeat (2) @(negedge clk);
        sda_m = bit_v;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        seen = sda_line;
        repeat (1) @(negedge clk);
    endtask

    task automatic t_start();
        @(negedge clk);
        scl = 1'b0;
        exp_pull = 1'b0;
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        sda_m = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_stop();
        @(negedge clk);
        scl = 1'b0;
        exp_pull = 1'b0;
        repeat (2) @(negedge clk);
        sda_m = 1'b0;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] b, input logic ack_exp, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, s);
        slot(1'b1, ack_exp, s);
        chk(s == ~ack_exp, tag, s, ~ack_exp);
    endtask

    task automatic t_addr(input logic [6:0] a, input logic rw, input logic ack_exp, input string tag);
        send_raw({a, rw}, ack_exp, tag);
    endtask

    task automatic t_setptr(input logic [7:0] p);
        send_raw(p, 1'b1, "R4 pointer byte ack");
        model_ptr = p;
    endtask

    task automatic t_wbyte(input logic [7:0] b);
        if (model_ptr < REG_COUNT) begin
            q_addr.push_back(8'(model_ptr));
            q_data.push_back(b);
            model[model_ptr] = b;
        end
        model_ptr = (model_ptr + 1) % 256;
        send_raw(b, 1'b1, "R6 data byte ack");
    endtask

    task automatic t_rbyte(input logic mack, input string tag);
        logic [7:0] e, got;
        logic s;
        e = (model_ptr < REG_COUNT) ? model[model_ptr] : 8'h00;
        model_ptr = (model_ptr + 1) % 256;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, ~e[i], s);
            got[i] = s;
        end
        slot(~mack, 1'b0, s);
        chk(got == e, tag, got, e);
    endtask

    task automatic ptr_chk(input string tag);
        repeat (2) @(negedge clk);
        chk(rd_addr == 8'(model_ptr), tag, rd_addr, model_ptr);
    endtask

    initial begin
        n_chk = 0;
        n_fail = 0;
        mon_en = 1'b0;
        exp_pull = 1'b0;
        scl = 1'b1;
        sda_m = 1'b1;
        dev = 7'h2A;
        rst_n = 1'b0;
        model_ptr = 0;
        for (int i = 0; i < REG_COUNT; i++) begin
            rf[i] = 8'h50 + 8'(i);
            model[i] = 8'h50 + 8'(i);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sda_pull == 1'b0, "R11 line released after reset", sda_pull, 0);
        chk(wr_en == 1'b0, "R11 no write after reset", wr_en, 0);
        chk(rd_addr == '0, "R11 pointer zero after reset", rd_addr, 0);
        mon_en = 1'b1;

        // R4 / R5: pointer load then burst write
        t_start();
        t_addr(dev, 1'b0, 1'b1, "R2 write address ack");
        t_setptr(8'h01);
        t_wbyte(8'h11);
        t_wbyte(8'h22);
        t_wbyte(8'h33);
        t_stop();
        ptr_chk("R5 pointer stepped per byte, kept over STOP");

        // R7: sequential read with controller ACK then NACK
        t_start();
        t_addr(dev, 1'b1, 1'b1, "R2 read address ack");
        t_rbyte(1'b1, "R7 read byte at pointer");
        t_rbyte(1'b0, "R7 read next byte");
        t_stop();
        ptr_chk("R7 pointer after read");

        // R8: reads beyond the implemented window
        t_start();
        t_addr(dev, 1'b1, 1'b1, "R2 read address ack");
        t_rbyte(1'b1, "R8 unimplemented reads 00h");
        t_rbyte(1'b0, "R8 unimplemented reads 00h");
        t_stop();

        // R6: burst crossing the end of the window
        t_start();
        t_addr(dev, 1'b0, 1'b1, "R2 write address ack");
        t_setptr(8'h04);
        t_wbyte(8'hA4);
        t_wbyte(8'hA5);
        t_wbyte(8'hA6);
        t_wbyte(8'hA7);
        t_stop();
        ptr_chk("R6 pointer advances over dropped bytes");

        // R3: address mismatch
        t_start();
        t_addr(dev ^ 7'h01, 1'b0, 1'b0, "R3 mismatched address not acked");
        send_raw(8'h03, 1'b0, "R3 no ack after mismatch");
        send_raw(8'h77, 1'b0, "R3 no ack after mismatch");
        t_stop();
        ptr_chk("R3 pointer unchanged by mismatch");

        // R9: random read through repeated START
        t_start();
        t_addr(dev, 1'b0, 1'b1, "R2 write address ack");
        t_setptr(8'h02);
        t_start();
        t_addr(dev, 1'b1, 1'b1, "R9 read address after repeated START");
        t_rbyte(1'b1, "R9 random read first byte");
        t_rbyte(1'b1, "R9 random read second byte");
        t_rbyte(1'b0, "R9 random read third byte");
        t_stop();
        ptr_chk("R9 pointer after random read");

        // R1: START in the middle of a data byte aborts it
        t_start();
        t_addr(dev, 1'b0, 1'b1, "R2 write address ack");
        t_setptr(8'h03);
        begin
            logic s;
            for (int i = 0; i < 4; i++) slot(1'b1, 1'b0, s);
        end
        t_start();
        t_addr(dev, 1'b1, 1'b1, "R1 address after mid-byte START");
        t_rbyte(1'b0, "R1 aborted byte left register intact");
        t_stop();

        // R1: repeated START to a foreign address leaves pointer alone
        t_start();
        t_addr(dev ^ 7'h40, 1'b1, 1'b0, "R1 foreign address ignored");
        t_stop();
        ptr_chk("R1 pointer unchanged by foreign START and STOP");

        // R2: programmable address, R5: pointer wrap
        dev = 7'h11;
        t_start();
        t_addr(7'h2A, 1'b0, 1'b0, "R2 old address rejected");
        t_stop();
        t_start();
        t_addr(dev, 1'b0, 1'b1, "R2 new address acked");
        t_setptr(8'hFF);
        t_wbyte(8'h99);
        t_wbyte(8'h5C);
        t_stop();
        ptr_chk("R5 pointer wraps modulo 256");

        repeat (4) @(negedge clk);
        for (int i = 0; i < REG_COUNT; i++)
            chk(rf[i] == model[i], "R6 register contents", rf[i], model[i]);
        chk(q_addr.size() == 0, "R5 all expected writes seen", q_addr.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule